// File: doc/BRIEF.md
# Clock-Generator Serial Register Slave

This block is the control port of a clock synthesizer. It listens on a two-wire serial bus (a clock line and an open-drain data line) and keeps a small bank of 8-bit registers. Each bit of a writable register drives the enable line of one clock output buffer, so software can turn individual outputs on and off. One register slot holds a fixed silicon signature that can be read but not changed.

A transfer opens with a START condition. A 7-bit device address and a direction bit follow. On a write, a command byte comes next: its top bit must be 1, which selects a single-byte access, and its low seven bits pick the register offset. One data byte then completes the write. A read uses a repeated START with the direction bit set. The slave returns the register at the offset stored by the last accepted command, sending the most significant bit first. Both bus lines pass through two-flop synchronizers into the system clock domain before use. The slave pulls the data line low to acknowledge.

The bus controller is a state machine with these states: IDLE, ADDR (shifting in the address), ADDR_ACK, CMD (shifting in the command), CMD_ACK, WDATA, WDATA_ACK, RDATA (shifting out), RDATA_ACK (master's acknowledge) and IGNORE (silent until STOP). A STOP in any state leads to IDLE, and a START in any state leads to ADDR. Inside the states, the transitions are as follows. ADDR goes to ADDR_ACK on the eighth rising SCL edge. ADDR_ACK goes to IGNORE on a mismatch. On a match it goes to CMD for a write or to RDATA for a read, once the acknowledge clock has ended. CMD goes to CMD_ACK on its eighth bit. CMD_ACK then goes to IGNORE for a command byte without the single-byte bit, and to WDATA otherwise. WDATA goes to WDATA_ACK on its eighth bit, and WDATA_ACK goes to IGNORE. RDATA goes to RDATA_ACK after eight bits, and RDATA_ACK goes to IGNORE.

Top module: `clkgen_sreg_top`

## Requirements
- R1: START (SDA falling while SCL high) in any state restarts address reception, and STOP (SDA rising while SCL high) in any state returns the slave to idle. A transfer cut short by either leaves every register unchanged.
- R2: The address byte is sent MSB first: seven address bits, then a direction bit (0 write, 1 read). When the address equals DEV_ADDR (default 7'h69), the slave pulls SDA low through the whole ninth SCL clock.
- R3: When the address does not match, the slave gives no acknowledge and keeps SDA released until the next STOP. A write sent this way changes nothing, and a read sent this way sees all ones on the line.
- R4: A command byte with bit 7 set is acknowledged, and its bits 6:0 are stored as the register offset. A command byte with bit 7 clear is not acknowledged, and the rest of that transfer is ignored.
- R5: The data byte of a write is acknowledged and stored in the register at the stored offset.
- R6: A write takes only one data byte. Further bytes in the same transfer are not acknowledged and are not stored.
- R7: A read (address with direction 1) is acknowledged. It then shifts out the register at the stored offset, MSB first, changing SDA only while SCL is low, and releases SDA after the eighth bit. The offset may come from a command in the same transfer before a repeated START, or from an earlier transfer.
- R8: The signature register at offset 8 always reads 8'h01: the revision field (bits 7:4) is 0 and the vendor field (bits 3:0) is 1. Writes to it are acknowledged and ignored.
- R9: After reset every writable register holds 8'hFF. Output clk_en_o carries register k on bits [8k+7:8k], and the signature slot shows its fixed value.
- R10: Offsets at or above NUM_REGS (default 10) are acknowledged. Writes to them change nothing, and reads from them return 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| clk_en_o | output | NUM_REGS*8 | Register contents; each bit enables one clock output |

## Verification
On every cycle, the assertions check three things. A STOP forces the idle state and a START forces address reception. The slave never pulls SDA in idle or while ignoring the bus, and it only starts pulling SDA while SCL is low. Each write strobe coincides with the data-acknowledge state, lands in its register on the next cycle, and leaves the outputs unchanged when the offset is out of range. Whether an address or command is acknowledged, and the byte values read back, only the bench's bus scenarios can show. The same holds for the signature staying fixed after a write, a second data byte being refused, and a cut-short or restarted transfer leaving the registers untouched.

// File: rtl/clkgen_sreg_pkg.sv
package clkgen_sreg_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } sreg_state_e;
endpackage

// File: rtl/clkgen_sreg_sync.sv
module clkgen_sreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/clkgen_sreg_fsm.sv
module clkgen_sreg_fsm
    import clkgen_sreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       sda_pull,
    output logic       wr_en,
    output logic [6:0] reg_addr,
    output logic [7:0] wr_data
);
    sreg_state_e st, st_n;
    logic [3:0] cnt;
    logic [6:0] sh;
    logic [7:0] tx;
    logic       ack_half, ack_yes, rw_q;
    logic [7:0] byte_now;

    assign byte_now = {sh, sda_s};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        if (stop_det) begin
            st_n = ST_IDLE;
        end else if (start_det) begin
            st_n = ST_ADDR;
        end else begin
            unique case (st)
                ST_IDLE:      st_n = ST_IDLE;
                ST_ADDR:      if (scl_rise && cnt == 4'd7) st_n = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall) begin
                                  if (!ack_half) st_n = ack_yes ? ST_ADDR_ACK : ST_IGNORE;
                                  else           st_n = rw_q ? ST_RDATA : ST_CMD;
                              end
                ST_CMD:       if (scl_rise && cnt == 4'd7) st_n = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) begin
                                  if (!ack_half) st_n = ack_yes ? ST_CMD_ACK : ST_IGNORE;
                                  else           st_n = ST_WDATA;
                              end
                ST_WDATA:     if (scl_rise && cnt == 4'd7) st_n = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall && ack_half) st_n = ST_IGNORE;
                ST_RDATA:     if (scl_fall && cnt == 4'd8) st_n = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_rise) st_n = ST_IGNORE;
                ST_IGNORE:    st_n = ST_IGNORE;
                default:      st_n = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            ack_half <= 1'b0;
            ack_yes  <= 1'b0;
            rw_q     <= 1'b0;
            reg_addr <= '0;
            wr_data  <= '0;
            wr_en    <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            wr_en <= 1'b0;

            if (start_det || st_n != st) cnt <= '0;
            else if (scl_rise)           cnt <= cnt + 4'd1;

            if (scl_rise) sh <= byte_now[6:0];

            if (st_n != st)    ack_half <= 1'b0;
            else if (scl_fall) ack_half <= 1'b1;

            if (st_n == ST_ADDR_ACK && st == ST_ADDR) begin
                ack_yes <= (byte_now[7:1] == DEV_ADDR);
                rw_q    <= byte_now[0];
            end
            if (st_n == ST_CMD_ACK && st == ST_CMD) begin
                ack_yes <= byte_now[7];
                if (byte_now[7]) reg_addr <= byte_now[6:0];
            end
            if (st_n == ST_WDATA_ACK && st == ST_WDATA) begin
                ack_yes <= 1'b1;
                wr_en   <= 1'b1;
                wr_data <= byte_now;
            end

            if (start_det || stop_det) begin
                sda_pull <= 1'b0;
            end else if (st_n == ST_RDATA && st != ST_RDATA) begin
                tx       <= rd_data;
                sda_pull <= ~rd_data[7];
            end else if (st == ST_RDATA && scl_fall) begin
                tx       <= {tx[6:0], 1'b0};
                sda_pull <= (cnt == 4'd8) ? 1'b0 : ~tx[6];
            end else if ((st == ST_ADDR_ACK || st == ST_CMD_ACK || st == ST_WDATA_ACK)
                         && scl_fall && !ack_half && st_n == st) begin
                sda_pull <= 1'b1;
            end else if (st_n != st) begin
                sda_pull <= 1'b0;
            end
        end
    end

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> st == ST_IDLE);                                   // R1
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> st == ST_ADDR);                                  // R1
    AST_QUIET_WHEN_IGNORING: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE || st == ST_IDLE) |-> !sda_pull);             // R3
    AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);                                   // R7
    AST_WRITE_IN_DATA_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> st == ST_WDATA_ACK);                                 // R5
endmodule

// File: rtl/clkgen_sreg_bank.sv
module clkgen_sreg_bank #(
    parameter int         NUM_REGS   = 10,
    parameter int         SIG_OFFSET = 8,
    parameter logic [7:0] SIG_VALUE  = 8'h01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [6:0]            addr,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        if (k == SIG_OFFSET) begin : g_sig
            assign regs_flat[8*k +: 8] = SIG_VALUE;
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          q <= 8'hFF;
                else if (wr_en && addr == 7'(k))     q <= wr_data;
            end
            assign regs_flat[8*k +: 8] = q;

            AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == 7'(k)) |=> q == $past(wr_data));     // R5
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (addr == 7'(k)) rd_data = regs_flat[8*k +: 8];
        end
    end

    AST_RANGE_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) >= NUM_REGS) |=> $stable(regs_flat));     // R10
endmodule

// File: rtl/clkgen_sreg_top.sv
module clkgen_sreg_top #(
    parameter logic [6:0] DEV_ADDR   = 7'h69,
    parameter int         NUM_REGS   = 10,
    parameter int         SIG_OFFSET = 8,
    parameter logic [3:0] SIG_REV    = 4'h0,
    parameter logic [3:0] SIG_VEN    = 4'h1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] clk_en_o
);
    localparam logic [7:0] SIG_VALUE = {SIG_REV, SIG_VEN};

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [6:0] reg_addr;
    logic [7:0] wr_data, rd_data;

    clkgen_sreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    clkgen_sreg_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
        .sda_pull(sda_pull_o), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data)
    );

    clkgen_sreg_bank #(.NUM_REGS(NUM_REGS), .SIG_OFFSET(SIG_OFFSET), .SIG_VALUE(SIG_VALUE)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .regs_flat(clk_en_o)
    );
endmodule

// File: tb/tb_clkgen_sreg_top.sv
module tb_clkgen_sreg_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 12;
    localparam int NREG       = 10;
    localparam int EW         = NREG*8;
    localparam logic [6:0] ADDR = 7'h69;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_pull;
    logic [EW-1:0] clk_en;
    logic sda_w;

    assign sda_w = !(m_low || sda_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_sreg_top dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_w),
        .sda_pull_o(sda_pull), .clk_en_o(clk_en)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string         exp_tag[$];
    logic [EW-1:0] exp_val[$];
    logic [EW-1:0] act_val[$];
    event act_ev;
    logic [EW-1:0] model;

    task automatic sb_expect(string tag, logic [EW-1:0] v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    task automatic sb_observe(logic [EW-1:0] v);
        act_val.push_back(v);
        -> act_ev;
    endtask

    task automatic chk(string tag, logic [EW-1:0] act, logic [EW-1:0] exp);
        sb_expect(tag, exp);
        sb_observe(act);
    endtask

    function automatic void drain();
        while (act_val.size() > 0) begin
            logic [EW-1:0] a, e;
            string t;
            a = act_val.pop_front();
            checks++;
            if (exp_val.size() == 0) begin
                failures++;
                $display("FAIL unmatched actual=%h expected=none", a);
            end else begin
                e = exp_val.pop_front();
                t = exp_tag.pop_front();
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    endfunction

    initial forever begin
        @(act_ev);
        drain();
    end

    task automatic q(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; q(HALF);
        scl = 1'b1;   q(HALF);
        m_low = 1'b1; q(HALF);
        scl = 1'b0;   q(2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; q(HALF);
        scl = 1'b1;   q(HALF);
        m_low = 1'b0; q(HALF);
    endtask

    task automatic send_bit(logic b);
        m_low = ~b; q(HALF);
        scl = 1'b1; q(HALF);
        scl = 1'b0; q(2);
    endtask

    task automatic send_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; q(HALF);
        scl = 1'b1;   q(HALF/2);
        acked = ~sda_w;
        q(HALF/2);
        scl = 1'b0;   q(2);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic master_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            q(HALF);
            scl = 1'b1; q(HALF/2);
            d[i] = sda_w;
            q(HALF/2);
            scl = 1'b0; q(2);
        end
        m_low = master_ack; q(HALF);
        scl = 1'b1; q(HALF);
        scl = 1'b0; q(2);
        m_low = 1'b0;
    endtask

    task automatic wr_xfer(logic [6:0] a, logic [7:0] cmd, logic [7:0] d,
                           output logic a1, output logic a2, output logic a3);
        bus_start();
        send_byte({a, 1'b0}, a1);
        send_byte(cmd, a2);
        send_byte(d, a3);
        bus_stop();
    endtask

    task automatic rd_xfer(logic [7:0] cmd, output logic [7:0] d, output logic a3);
        logic x;
        bus_start();
        send_byte({ADDR, 1'b0}, x);
        send_byte(cmd, x);
        bus_start();
        send_byte({ADDR, 1'b1}, a3);
        recv_byte(d, 1'b0);
        bus_stop();
    endtask

    function automatic logic [EW-1:0] ext8(logic [7:0] v);
        return {{(EW-8){1'b0}}, v};
    endfunction

    function automatic logic [EW-1:0] ext1(logic v);
        return {{(EW-1){1'b0}}, v};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic a1, a2, a3, x;
        logic [7:0] d;
        model = {NREG{8'hFF}};
        model[8*8 +: 8] = 8'h01;
        q(5);
        rst_n = 1'b1;
        q(5);
        chk("R9 reset enables", clk_en, model);

        // R2 R4 R5: plain write to register 3
        wr_xfer(ADDR, 8'h83, 8'h5A, a1, a2, a3);
        chk("R2 address ack", ext1(a1), ext1(1'b1));
        chk("R4 command ack", ext1(a2), ext1(1'b1));
        chk("R5 data ack", ext1(a3), ext1(1'b1));
        model[3*8 +: 8] = 8'h5A;
        chk("R5 register 3 written", clk_en, model);

        // R7: read register 3 back
        rd_xfer(8'h83, d, a3);
        chk("R7 read address ack", ext1(a3), ext1(1'b1));
        chk("R7 read reg3", ext8(d), ext8(8'h5A));

        // R7: all-zero pattern in register 0
        wr_xfer(ADDR, 8'h80, 8'h00, a1, a2, a3);
        model[0 +: 8] = 8'h00;
        chk("R9 register 0 slot", clk_en, model);
        rd_xfer(8'h80, d, a3);
        chk("R7 read reg0 zeros", ext8(d), ext8(8'h00));

        // R8: signature read, write attempt, re-read
        rd_xfer(8'h88, d, a3);
        chk("R8 signature value", ext8(d), ext8(8'h01));
        wr_xfer(ADDR, 8'h88, 8'h77, a1, a2, a3);
        chk("R8 signature write acked", ext1(a3), ext1(1'b1));
        chk("R8 enables unchanged", clk_en, model);
        rd_xfer(8'h88, d, a3);
        chk("R8 signature after write", ext8(d), ext8(8'h01));

        // R3: wrong address write and read
        wr_xfer(7'h2C, 8'h82, 8'h11, a1, a2, a3);
        chk("R3 wrong address nack", ext1(a1), ext1(1'b0));
        chk("R3 wrong address no write", clk_en, model);
        bus_start();
        send_byte({7'h2C, 1'b1}, a1);
        recv_byte(d, 1'b1);
        bus_stop();
        chk("R3 wrong address read released", ext8(d), ext8(8'hFF));

        // R4: command without single-byte bit
        wr_xfer(ADDR, 8'h05, 8'h22, a1, a2, a3);
        chk("R4 command bit7 clear nack", ext1(a2), ext1(1'b0));
        chk("R4 no write after refused command", clk_en, model);

        // R6: second data byte refused
        bus_start();
        send_byte({ADDR, 1'b0}, a1);
        send_byte(8'h81, a2);
        send_byte(8'h3C, a3);
        send_byte(8'hC3, x);
        bus_stop();
        chk("R6 second byte nack", ext1(x), ext1(1'b0));
        model[1*8 +: 8] = 8'h3C;
        chk("R6 only first byte stored", clk_en, model);

        // R10: offset beyond the bank
        wr_xfer(ADDR, 8'hD0, 8'h99, a1, a2, a3);
        chk("R10 high offset acked", ext1(a3), ext1(1'b1));
        chk("R10 high offset no write", clk_en, model);
        rd_xfer(8'hD0, d, a3);
        chk("R10 high offset reads zero", ext8(d), ext8(8'h00));

        // R1: STOP before the data byte
        bus_start();
        send_byte({ADDR, 1'b0}, a1);
        send_byte(8'h84, a2);
        bus_stop();
        chk("R1 stop before data no write", clk_en, model);

        // R1: START in the middle of an address, then a full write
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte({ADDR, 1'b0}, a1);
        send_byte(8'h84, a2);
        send_byte(8'hA5, a3);
        bus_stop();
        model[4*8 +: 8] = 8'hA5;
        chk("R1 restart then write", clk_en, model);

        // R7: read without a command uses the stored offset (4)
        bus_start();
        send_byte({ADDR, 1'b1}, a1);
        recv_byte(d, 1'b1);
        bus_stop();
        chk("R7 read with stored offset", ext8(d), ext8(8'hA5));

        q(5);
        drain();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule